// File: doc/BRIEF.md
# SDRAM Write Burst Engine

This block sits on the controller side of an SDRAM interface. It turns a stream of write beats into WRITE commands on the device command pins, with the matching data on the DQ bus. A beat flagged as the start of a burst carries the bank, the starting column and an auto-precharge choice. That beat becomes a WRITE command, and its data is driven on DQ in the same cycle, with no write latency. Later beats fill the rest of the burst, one per clock.

The burst length is fixed when the block is built. It is 1, 2, 4 or 8 beats, or a full page. A fixed burst stops by itself. A full-page burst keeps running until a new WRITE replaces it, and the device column address wraps from the last column of the page to column 0. A new start beat is taken on any cycle. It cuts off the burst in progress at once, and its data belongs to the new command.

The target row is assumed to be open already. Activation, refresh, reads and device initialization are handled elsewhere.

Top module: `sdram_wr_burst`

## Requirements
- R1: A start beat that is accepted at clock edge k appears after edge k as a WRITE command, and its data is driven on DQ in that same cycle (`sd_dq_oe`=1, `sd_dqm`=0).
- R2: The command pins {cs_n,ras_n,cas_n,we_n} show 0100 for WRITE and 0111 (NOP) in every other cycle. During reset and after it, the pins show NOP with `sd_dq_oe`=0, `sd_dqm` all ones, and `sd_ba`, `sd_addr` and `sd_dq_out` all zero.
- R3: In a WRITE cycle, `sd_ba` carries the bank and `sd_addr[COL_W-1:0]` carries the column. Bit `sd_addr[10]` carries the auto-precharge flag (1 = precharge when the burst ends). All other address bits are 0. In NOP cycles, `sd_ba` and `sd_addr` are 0.
- R4: A fixed burst of BURST_LEN beats occupies the WRITE cycle and the BURST_LEN-1 cycles after it. After that, `sd_dq_oe` is low, `wr_ready` is low for beats that are not start beats, and such beats are not consumed.
- R5: With BURST_LEN=0 (full page), one beat goes out in every cycle after the WRITE, with no end. The device column therefore runs from 2^COL_W-1 back to 0 and continues.
- R6: A valid start beat is accepted on any cycle, including inside a burst and directly after another WRITE. It issues a new WRITE that cuts off the old burst, and the new beat's data goes out with that command.
- R7: A burst slot in which `wr_valid` is low still takes up its cycle. DQ is driven with `sd_dqm` high, so the beat is masked, and the burst advances.
- R8: `sd_dqm` is low on every data beat and high whenever `sd_dq_oe` is low.
- R9: `wr_ready` is high when `wr_first` is high, or when the current cycle is a slot of a running burst. It is low otherwise. A start beat with `wr_valid` low issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Beat present |
| wr_ready | output | 1 | Beat accepted this cycle when valid |
| wr_first | input | 1 | Beat starts a new burst |
| wr_bank | input | BANK_W | Bank of the start beat |
| wr_col | input | COL_W | Starting column of the start beat |
| wr_autopre | input | 1 | Auto-precharge request of the start beat |
| wr_data | input | DATA_W | Beat data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select pins |
| sd_addr | output | ADDR_W | Address pins; bit 10 is auto precharge |
| sd_dq_out | output | DATA_W | DQ drive value |
| sd_dq_oe | output | 1 | DQ output enable |
| sd_dqm | output | DQM_W | Data mask, high masks the beat |

## Verification
Every device pin changes exactly one clock edge after the beat that causes it is sampled. The bench drives each beat on a falling edge and reads the pin results at the next falling edge, which is half a cycle after the register updates. `wr_ready` is combinational, so it is read one time step after the inputs change, within the same cycle. The full-page instance is checked through a capture model. The model follows each column from the address pins sampled at the WRITE cycle and advances by one per beat, so a correct wrap shows up as the right final contents at columns 0, 1, 14 and 15.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_cmd_t;

   localparam sd_cmd_t SD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam sd_cmd_t SD_WRITE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};

   typedef struct packed {
      logic start;     // new WRITE issued this cycle
      logic slot;      // a beat occupies DQ this cycle
      logic has_data;  // that beat carries real data
   } beat_ctl_t;

endpackage

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
   import sdram_wr_pkg::*;
#(
   parameter int BURST_LEN = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_valid,
   input  logic      wr_first,
   output logic      wr_ready,
   output beat_ctl_t ctl
);

   logic start;
   logic cont;

   assign start        = wr_valid & wr_first;
   assign wr_ready     = wr_first | cont;
   assign ctl.start    = start;
   assign ctl.slot     = start | cont;
   assign ctl.has_data = start | (cont & wr_valid);

   generate
      if (BURST_LEN == 0) begin : g_page
         logic active;
         always_ff @(posedge clk) begin
            if (!rst_n)     active <= 1'b0;
            else if (start) active <= 1'b1;
         end
         assign cont = active & ~start;
      end else begin : g_fixed
         localparam int CNT_W = $clog2(BURST_LEN) + 1;
         logic [CNT_W-1:0] rem;
         logic [7:0]       seen;   // checker counter: beats since last WRITE

         always_ff @(posedge clk) begin
            if (!rst_n)     rem <= '0;
            else if (start) rem <= CNT_W'(BURST_LEN - 1);
            else if (cont)  rem <= rem - 1'b1;
         end
         assign cont = (rem != '0) & ~start;

         always_ff @(posedge clk) begin
            if (!rst_n)        seen <= '0;
            else if (start)    seen <= 8'd1;
            else if (ctl.slot) seen <= seen + 8'd1;
         end

         assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl.slot && !start) |-> (seen < 8'(BURST_LEN)));
      end
   endgenerate

endmodule

// File: rtl/sdram_wr_pins.sv
module sdram_wr_pins
   import sdram_wr_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int COL_W  = 8,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16,
   parameter int DQM_W  = 2,
   parameter int AP_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  beat_ctl_t         ctl,
   input  logic [BANK_W-1:0] bank,
   input  logic [COL_W-1:0]  col,
   input  logic              autopre,
   input  logic [DATA_W-1:0] data,
   output sd_cmd_t           cmd,
   output logic [BANK_W-1:0] ba,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dq,
   output logic              dq_oe,
   output logic [DQM_W-1:0]  dqm
);

   logic [ADDR_W-1:0] col_addr;
   logic              real_beat;

   always_comb begin
      col_addr              = '0;
      col_addr[COL_W-1:0]   = col;
      col_addr[AP_BIT]      = autopre;
   end

   assign real_beat = ctl.slot & ctl.has_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd   <= SD_NOP;
         ba    <= '0;
         addr  <= '0;
         dq    <= '0;
         dq_oe <= 1'b0;
         dqm   <= '1;
      end else begin
         cmd   <= ctl.start ? SD_WRITE : SD_NOP;
         ba    <= ctl.start ? bank : '0;
         addr  <= ctl.start ? col_addr : '0;
         dq    <= real_beat ? data : '0;
         dq_oe <= ctl.slot;
         dqm   <= real_beat ? '0 : '1;
      end
   end

   assert_write_has_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == SD_WRITE) |-> (dq_oe && dqm == '0));
   assert_idle_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> (dqm == '1));
   assert_nop_quiet_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == SD_NOP) |-> (ba == '0 && addr == '0));

endmodule

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst
   import sdram_wr_pkg::*;
#(
   parameter int BANK_W    = 2,
   parameter int COL_W     = 8,
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 16,
   parameter int BURST_LEN = 4,   // 1, 2, 4, 8, or 0 for full page
   parameter int AP_BIT    = 10,
   localparam int DQM_W    = (DATA_W + 7) / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic              wr_first,
   input  logic [BANK_W-1:0] wr_bank,
   input  logic [COL_W-1:0]  wr_col,
   input  logic              wr_autopre,
   input  logic [DATA_W-1:0] wr_data,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [DATA_W-1:0] sd_dq_out,
   output logic              sd_dq_oe,
   output logic [DQM_W-1:0]  sd_dqm
);

   generate
      if (!(BURST_LEN == 0 || BURST_LEN == 1 || BURST_LEN == 2 ||
            BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_len
         $error("BURST_LEN must be 0, 1, 2, 4 or 8");
      end
      if (COL_W > AP_BIT || AP_BIT >= ADDR_W) begin : g_bad_addr
         $error("column field must sit below the auto-precharge bit");
      end
      if (BANK_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("bank and data widths must be positive");
      end
   endgenerate

   beat_ctl_t ctl;
   sd_cmd_t   cmd;

   sdram_wr_seq #(.BURST_LEN(BURST_LEN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_first (wr_first),
      .wr_ready (wr_ready),
      .ctl      (ctl)
   );

   sdram_wr_pins #(
      .BANK_W (BANK_W), .COL_W (COL_W), .ADDR_W (ADDR_W),
      .DATA_W (DATA_W), .DQM_W (DQM_W), .AP_BIT (AP_BIT)
   ) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl),
      .bank    (wr_bank),
      .col     (wr_col),
      .autopre (wr_autopre),
      .data    (wr_data),
      .cmd     (cmd),
      .ba      (sd_ba),
      .addr    (sd_addr),
      .dq      (sd_dq_out),
      .dq_oe   (sd_dq_oe),
      .dqm     (sd_dqm)
   );

   assign sd_cs_n  = cmd.cs_n;
   assign sd_ras_n = cmd.ras_n;
   assign sd_cas_n = cmd.cas_n;
   assign sd_we_n  = cmd.we_n;

   assert_start_any_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_first) |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0100));

   generate
      if (BURST_LEN == 0) begin : g_page_chk
         assert_page_runs_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !$fell(sd_dq_oe));
      end
   endgenerate

endmodule

// File: tb/sdram_wr_burst_test.sv
module sdram_wr_burst_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   int errors = 0;
   int checks = 0;

   // ---- fixed burst instance (BURST_LEN = 4) ----
   logic        wr_valid = 0, wr_first = 0, wr_autopre = 0, wr_ready;
   logic [1:0]  wr_bank = 0;
   logic [7:0]  wr_col = 0;
   logic [15:0] wr_data = 0;
   logic        cs_n, ras_n, cas_n, we_n, dq_oe;
   logic [1:0]  ba, dqm;
   logic [11:0] addr;
   logic [15:0] dq;

   sdram_wr_burst #(.COL_W(8), .BURST_LEN(4)) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_first(wr_first), .wr_bank(wr_bank), .wr_col(wr_col),
      .wr_autopre(wr_autopre), .wr_data(wr_data),
      .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
      .sd_ba(ba), .sd_addr(addr), .sd_dq_out(dq), .sd_dq_oe(dq_oe), .sd_dqm(dqm));

   // ---- full page instance (16 columns) ----
   logic        fp_valid = 0, fp_first = 0, fp_ready;
   logic [3:0]  fp_col = 0;
   logic [15:0] fp_data = 0;
   logic        fp_cs_n, fp_ras_n, fp_cas_n, fp_we_n, fp_oe;
   logic [1:0]  fp_ba, fp_dqm;
   logic [11:0] fp_addr;
   logic [15:0] fp_dq;

   sdram_wr_burst #(.COL_W(4), .BURST_LEN(0)) uut_fp (
      .clk(clk), .rst_n(rst_n), .wr_valid(fp_valid), .wr_ready(fp_ready),
      .wr_first(fp_first), .wr_bank(2'd0), .wr_col(fp_col),
      .wr_autopre(1'b0), .wr_data(fp_data),
      .sd_cs_n(fp_cs_n), .sd_ras_n(fp_ras_n), .sd_cas_n(fp_cas_n), .sd_we_n(fp_we_n),
      .sd_ba(fp_ba), .sd_addr(fp_addr), .sd_dq_out(fp_dq), .sd_dq_oe(fp_oe), .sd_dqm(fp_dqm));

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // capture model of the device columns for the full page instance
   logic [15:0] mem [16];
   logic [3:0]  ptr = 0;
   task automatic capture();
      if (fp_oe && {fp_cs_n, fp_ras_n, fp_cas_n, fp_we_n} == 4'b0100) ptr = fp_addr[3:0];
      if (fp_oe) begin
         if (fp_dqm == 2'b00) mem[ptr] = fp_dq;
         ptr = ptr + 4'd1;
      end
   endtask

   typedef struct packed {
      logic v; logic f; logic [1:0] bank; logic [7:0] col; logic ap; logic [15:0] data;
      logic rdy; logic [3:0] cmd; logic oe; logic dqm; logic [1:0] ba; logic [11:0] addr;
      logic [15:0] dq;
   } vec_t;

   localparam logic [3:0] W = 4'b0100, N = 4'b0111;
   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b1,2'd1,8'h10,1'b0,16'hA000, 1'b1,W,1'b1,1'b0,2'd1,12'h010,16'hA000},
      '{1'b1,1'b0,2'd0,8'h00,1'b0,16'hA001, 1'b1,N,1'b1,1'b0,2'd0,12'h000,16'hA001},
      '{1'b0,1'b0,2'd0,8'h00,1'b0,16'hDEAD, 1'b1,N,1'b1,1'b1,2'd0,12'h000,16'h0000},
      '{1'b1,1'b0,2'd0,8'h00,1'b0,16'hA003, 1'b1,N,1'b1,1'b0,2'd0,12'h000,16'hA003},
      '{1'b1,1'b0,2'd0,8'h00,1'b0,16'hBEEF, 1'b0,N,1'b0,1'b1,2'd0,12'h000,16'h0000},
      '{1'b1,1'b1,2'd2,8'hFE,1'b1,16'hB000, 1'b1,W,1'b1,1'b0,2'd2,12'h4FE,16'hB000},
      '{1'b1,1'b0,2'd0,8'h00,1'b0,16'hB001, 1'b1,N,1'b1,1'b0,2'd0,12'h000,16'hB001},
      '{1'b1,1'b1,2'd3,8'h20,1'b0,16'hC000, 1'b1,W,1'b1,1'b0,2'd3,12'h020,16'hC000},
      '{1'b1,1'b1,2'd0,8'h21,1'b0,16'hC100, 1'b1,W,1'b1,1'b0,2'd0,12'h021,16'hC100},
      '{1'b1,1'b0,2'd0,8'h00,1'b0,16'hC101, 1'b1,N,1'b1,1'b0,2'd0,12'h000,16'hC101},
      '{1'b1,1'b0,2'd0,8'h00,1'b0,16'hC102, 1'b1,N,1'b1,1'b0,2'd0,12'h000,16'hC102},
      '{1'b1,1'b0,2'd0,8'h00,1'b0,16'hC103, 1'b1,N,1'b1,1'b0,2'd0,12'h000,16'hC103},
      '{1'b0,1'b0,2'd0,8'h00,1'b0,16'h0000, 1'b0,N,1'b0,1'b1,2'd0,12'h000,16'h0000},
      '{1'b0,1'b1,2'd0,8'h00,1'b0,16'h0000, 1'b1,N,1'b0,1'b1,2'd0,12'h000,16'h0000}
   };
   localparam string TAG [NV] = '{"R1","R1","R7","R1","R4","R3","R1","R6","R6",
                                  "R1","R1","R4","R4","R9"};

   task automatic check_pins(input int i);
      chk("R2", $sformatf("step %0d cmd", i), {cs_n, ras_n, cas_n, we_n}, VEC[i].cmd);
      chk("R3", $sformatf("step %0d ba/addr", i), {ba, addr}, {VEC[i].ba, VEC[i].addr});
      chk(TAG[i], $sformatf("step %0d oe/dqm/dq", i), {dq_oe, dqm, dq},
          {VEC[i].oe, {2{VEC[i].dqm}}, VEC[i].dq});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2", "reset cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      chk("R2", "reset oe/dqm/ba/addr/dq", {dq_oe, dqm, ba, addr, dq}, {1'b0, 2'b11, 30'd0});
      rst_n = 1'b1;

      // vector walk on the fixed burst instance
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         if (i > 0) check_pins(i - 1);
         wr_valid = VEC[i].v; wr_first = VEC[i].f; wr_bank = VEC[i].bank;
         wr_col = VEC[i].col; wr_autopre = VEC[i].ap; wr_data = VEC[i].data;
         #1;
         chk("R9", $sformatf("step %0d ready", i), {31'd0, wr_ready}, {31'd0, VEC[i].rdy});
      end
      @(negedge clk);
      check_pins(NV - 1);
      wr_valid = 0; wr_first = 0;

      // R5: full page burst from column 14, 20 beats, wraps past column 15
      for (int c = 0; c < 16; c++) mem[c] = 16'hFFFF;
      fp_valid = 1; fp_first = 1; fp_col = 4'd14; fp_data = 16'd0;
      for (int k = 1; k < 20; k++) begin
         @(negedge clk);
         capture();
         fp_first = 0; fp_data = 16'(k);
      end
      @(negedge clk);
      capture();
      fp_valid = 0;
      chk("R5", "col 14 final", {16'd0, mem[14]}, 32'd16);
      chk("R5", "col 15 final", {16'd0, mem[15]}, 32'd17);
      chk("R5", "col 0 after wrap", {16'd0, mem[0]}, 32'd18);
      chk("R5", "col 1 after wrap", {16'd0, mem[1]}, 32'd19);
      // R7: slots without data stay driven but masked; burst keeps going
      repeat (3) begin
         @(negedge clk);
         capture();
         chk("R7", "page masked slot", {fp_oe, fp_dqm}, {1'b1, 2'b11});
      end
      chk("R5", "page ready mid-burst", {31'd0, fp_ready}, 32'd1);
      // R6: new WRITE cuts the page burst
      fp_valid = 1; fp_first = 1; fp_col = 4'd3; fp_data = 16'h5555;
      @(negedge clk);
      capture();
      chk("R6", "page truncate cmd", {fp_cs_n, fp_ras_n, fp_cas_n, fp_we_n, fp_addr}, {4'b0100, 12'h003});
      chk("R6", "page truncate data", {15'd0, fp_dqm == 2'b00, fp_dq}, {15'd0, 1'b1, 16'h5555});
      fp_valid = 0; fp_first = 0;
      @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule